// File: doc/BRIEF.md
# Passive Serial Configuration Master

This controller loads a configuration bitstream into a downstream programmable device over a three-wire passive serial link. A single start pulse, qualified by a total byte count, launches one complete load. The controller first resets the target by pulling an active-low configuration request low for a programmed hold time. It then releases the request, waits a settle time, and polls the target's active-low status line until the target lets it go high, with a bounded timeout.

Bitstream bytes are then taken one at a time from a valid/ready byte stream. Each byte is shifted out least significant bit first. The serial clock is low while a bit is presented, and the target samples on the rising edge. After the last byte the target's done flag must be high. The controller then issues a fixed burst of trailing clock cycles and reports success. Any failed step stops the load, parks the link and latches a two-bit error code.

All delays are counts of the system clock. The defaults suit a 50 MHz clock: a 2 µs hold, a 2 µs settle, a 100 ms release timeout and a serial clock at half the system rate.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset the request line is high, the serial clock, serial data, ready, busy, success and fail are low, and the error code is 2'b00.
- R2: A start pulse drives the request line low for HOLD_CYC cycles. If the status line is not low at the end of that hold, the load aborts with error code 2'b01.
- R3: After the hold, the request line is released and SETTLE_CYC cycles pass before polling begins. If the status line stays low for TIMEOUT_CYC polling cycles, the load aborts with error code 2'b10.
- R4: Each byte is sent least significant bit first as exactly eight rising edges of the serial clock. The data bit is stable at each rising edge, and every clock phase lasts HALF_CYC cycles.
- R5: Ready rises only after the previous byte's eighth bit has completed (or after the status release, for the first byte). A byte is taken only on a cycle where valid and ready are both high, and the serial clock is low whenever ready is high.
- R6: After the last byte, a low done flag aborts the load with error code 2'b11, and no trailing clocks are issued.
- R7: With done high, exactly TRAIL_CLKS (12) further rising edges of the serial clock are issued. Success is then reported with error code 2'b00.
- R8: On any abort the request line returns high, the serial clock and data go low, and fail and the error code hold their values until the next accepted start.
- R9: A start pulse while busy is ignored: the request line is not pulled low again and the load in progress completes unchanged.
- R10: A byte count of zero skips data transfer entirely. No byte is requested, and the done check follows the status release directly.
- R11: Success and fail are never high together, and the serial clock is high only while the request line is high and the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that begins a load |
| byte_count_i | input | CNT_W | Number of bitstream bytes, sampled on start |
| byte_data_i | input | 8 | Bitstream byte |
| byte_valid_i | input | 1 | Byte on byte_data_i is valid |
| byte_ready_o | output | 1 | Controller will take a byte this cycle |
| cfg_req_n_o | output | 1 | Active-low configuration request to the target |
| sclk_o | output | 1 | Serial clock to the target |
| sdata_o | output | 1 | Serial data to the target |
| status_n_i | input | 1 | Active-low status from the target |
| done_i | input | 1 | Configuration-done flag from the target |
| busy_o | output | 1 | A load is in progress |
| success_o | output | 1 | Last load completed, held until next start |
| fail_o | output | 1 | Last load aborted, held until next start |
| err_code_o | output | 2 | 00 none, 01 status not asserted, 10 release timeout, 11 done missing |

## Verification
The cycle-level assertions cover several invariants on every cycle: the parked link after an abort, the stability of the latched error code while idle, the quiet serial clock while ready is up, clocking only with the request released, and the pairing of the error code with success or fail. Other behaviours can only be shown by the bench's scenarios against a model of the target. These are the bit order and count per byte, the hold length, the exact number of trailing clocks, the timeout branch, a zero-length load, and a second start ignored mid-load.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'b00,
    ERR_NO_STATUS = 2'b01,
    ERR_TIMEOUT   = 2'b10,
    ERR_NO_DONE   = 2'b11
  } cfg_err_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_HOLD,
    S_SETTLE,
    S_POLL,
    S_FETCH,
    S_BIT_LO,
    S_BIT_HI,
    S_CHECK,
    S_TR_HI,
    S_TR_LO
  } cfg_state_e;

  function automatic int cfg_max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/cfg_delay_timer.sv
module cfg_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/cfg_byte_shifter.sv
module cfg_byte_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_i,
  input  logic [BITS-1:0] byte_i,
  input  logic            shift_i,
  output logic            next_bit_o,
  output logic            last_o
);

  localparam int CW = $clog2(BITS);

  logic [BITS-1:0] sr_q;
  logic [CW-1:0]   idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sr_q  <= byte_i;
      idx_q <= '0;
    end else if (shift_i) begin
      sr_q  <= {1'b0, sr_q[BITS-1:1]};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign next_bit_o = sr_q[1];
  assign last_o     = (idx_q == CW'(BITS - 1));

endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
  import ps_cfg_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int HOLD_CYC    = 100,
  parameter int SETTLE_CYC  = 100,
  parameter int TIMEOUT_CYC = 5000000,
  parameter int HALF_CYC    = 1,
  parameter int TRAIL_CLKS  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] byte_count_i,
  input  logic [7:0]       byte_data_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  output logic             cfg_req_n_o,
  output logic             sclk_o,
  output logic             sdata_o,
  input  logic             status_n_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic             success_o,
  output logic             fail_o,
  output logic [1:0]       err_code_o
);

  localparam int MAXC = cfg_max4(HOLD_CYC, SETTLE_CYC, TIMEOUT_CYC, HALF_CYC);
  localparam int TW   = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam int TRW  = $clog2(TRAIL_CLKS + 1);

  localparam logic [TW-1:0] T_HOLD    = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] T_SETTLE  = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] T_TIMEOUT = TW'(TIMEOUT_CYC - 1);
  localparam logic [TW-1:0] T_HALF    = TW'(HALF_CYC - 1);

  cfg_state_e       st_q, st_n;
  logic             cfgn_q, cfgn_n;
  logic             sclk_q, sclk_n;
  logic             sdat_q, sdat_n;
  logic             ready_q, ready_n;
  logic             succ_q, succ_n;
  logic             fail_q, fail_n;
  logic             busy_q;
  cfg_err_e         err_q, err_n;
  logic [CNT_W-1:0] rem_q, rem_n;
  logic [TRW-1:0]   trail_q, trail_n;

  logic             tmr_load;
  logic [TW-1:0]    tmr_val;
  logic             tmr_exp;
  logic             sh_load, sh_shift, sh_next, sh_last;
  logic             do_abort;
  cfg_err_e         abort_code;

  cfg_delay_timer #(.W(TW)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load_i   (tmr_load),
    .val_i    (tmr_val),
    .expired_o(tmr_exp)
  );

  cfg_byte_shifter #(.BITS(8)) i_shifter (
    .clk       (clk),
    .rst       (rst),
    .load_i    (sh_load),
    .byte_i    (byte_data_i),
    .shift_i   (sh_shift),
    .next_bit_o(sh_next),
    .last_o    (sh_last)
  );

  always_comb begin
    st_n       = st_q;
    cfgn_n     = cfgn_q;
    sclk_n     = sclk_q;
    sdat_n     = sdat_q;
    ready_n    = ready_q;
    succ_n     = succ_q;
    fail_n     = fail_q;
    err_n      = err_q;
    rem_n      = rem_q;
    trail_n    = trail_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    sh_load    = 1'b0;
    sh_shift   = 1'b0;
    do_abort   = 1'b0;
    abort_code = ERR_NONE;

    unique case (st_q)
      S_IDLE: begin
        if (start_i) begin
          st_n     = S_HOLD;
          cfgn_n   = 1'b0;
          succ_n   = 1'b0;
          fail_n   = 1'b0;
          err_n    = ERR_NONE;
          rem_n    = byte_count_i;
          tmr_load = 1'b1;
          tmr_val  = T_HOLD;
        end
      end
      S_HOLD: begin
        if (tmr_exp) begin
          if (!status_n_i) begin
            st_n     = S_SETTLE;
            cfgn_n   = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = T_SETTLE;
          end else begin
            do_abort   = 1'b1;
            abort_code = ERR_NO_STATUS;
          end
        end
      end
      S_SETTLE: begin
        if (tmr_exp) begin
          st_n     = S_POLL;
          tmr_load = 1'b1;
          tmr_val  = T_TIMEOUT;
        end
      end
      S_POLL: begin
        if (status_n_i) begin
          if (rem_q == '0) begin
            st_n = S_CHECK;
          end else begin
            st_n    = S_FETCH;
            ready_n = 1'b1;
          end
        end else if (tmr_exp) begin
          do_abort   = 1'b1;
          abort_code = ERR_TIMEOUT;
        end
      end
      S_FETCH: begin
        if (byte_valid_i && ready_q) begin
          sh_load  = 1'b1;
          sdat_n   = byte_data_i[0];
          ready_n  = 1'b0;
          rem_n    = rem_q - 1'b1;
          st_n     = S_BIT_LO;
          tmr_load = 1'b1;
          tmr_val  = T_HALF;
        end
      end
      S_BIT_LO: begin
        if (tmr_exp) begin
          sclk_n   = 1'b1;
          st_n     = S_BIT_HI;
          tmr_load = 1'b1;
          tmr_val  = T_HALF;
        end
      end
      S_BIT_HI: begin
        if (tmr_exp) begin
          sclk_n = 1'b0;
          if (!sh_last) begin
            sh_shift = 1'b1;
            sdat_n   = sh_next;
            st_n     = S_BIT_LO;
            tmr_load = 1'b1;
            tmr_val  = T_HALF;
          end else if (rem_q == '0) begin
            sdat_n = 1'b0;
            st_n   = S_CHECK;
          end else begin
            st_n    = S_FETCH;
            ready_n = 1'b1;
          end
        end
      end
      S_CHECK: begin
        if (done_i) begin
          sclk_n   = 1'b1;
          trail_n  = '0;
          st_n     = S_TR_HI;
          tmr_load = 1'b1;
          tmr_val  = T_HALF;
        end else begin
          do_abort   = 1'b1;
          abort_code = ERR_NO_DONE;
        end
      end
      S_TR_HI: begin
        if (tmr_exp) begin
          sclk_n   = 1'b0;
          st_n     = S_TR_LO;
          tmr_load = 1'b1;
          tmr_val  = T_HALF;
        end
      end
      S_TR_LO: begin
        if (tmr_exp) begin
          if (trail_q == TRW'(TRAIL_CLKS - 1)) begin
            st_n   = S_IDLE;
            succ_n = 1'b1;
          end else begin
            trail_n  = trail_q + 1'b1;
            sclk_n   = 1'b1;
            st_n     = S_TR_HI;
            tmr_load = 1'b1;
            tmr_val  = T_HALF;
          end
        end
      end
      default: st_n = S_IDLE;
    endcase

    if (do_abort) begin
      st_n    = S_IDLE;
      cfgn_n  = 1'b1;
      sclk_n  = 1'b0;
      sdat_n  = 1'b0;
      ready_n = 1'b0;
      fail_n  = 1'b1;
      err_n   = abort_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      cfgn_q  <= 1'b1;
      sclk_q  <= 1'b0;
      sdat_q  <= 1'b0;
      ready_q <= 1'b0;
      succ_q  <= 1'b0;
      fail_q  <= 1'b0;
      busy_q  <= 1'b0;
      err_q   <= ERR_NONE;
      rem_q   <= '0;
      trail_q <= '0;
    end else begin
      st_q    <= st_n;
      cfgn_q  <= cfgn_n;
      sclk_q  <= sclk_n;
      sdat_q  <= sdat_n;
      ready_q <= ready_n;
      succ_q  <= succ_n;
      fail_q  <= fail_n;
      busy_q  <= (st_n != S_IDLE);
      err_q   <= err_n;
      rem_q   <= rem_n;
      trail_q <= trail_n;
    end
  end

  assign byte_ready_o = ready_q;
  assign cfg_req_n_o  = cfgn_q;
  assign sclk_o       = sclk_q;
  assign sdata_o      = sdat_q;
  assign busy_o       = busy_q;
  assign success_o    = succ_q;
  assign fail_o       = fail_q;
  assign err_code_o   = err_q;

endmodule

// File: rtl/ps_cfg_checker.sv
module ps_cfg_checker (
  input logic       clk,
  input logic       rst,
  input logic       cfg_req_n_o,
  input logic       sclk_o,
  input logic       sdata_o,
  input logic       byte_ready_o,
  input logic       busy_o,
  input logic       success_o,
  input logic       fail_o,
  input logic [1:0] err_code_o
);

  p_abort_parked_r8: assert property (@(posedge clk) disable iff (rst)
    (fail_o && !busy_o) |-> (cfg_req_n_o && !sclk_o && !sdata_o));

  p_err_held_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && $past(!busy_o)) |-> $stable(err_code_o));

  p_ready_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    byte_ready_o |-> (!sclk_o && cfg_req_n_o && busy_o));

  p_clk_gated_r11: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> (cfg_req_n_o && busy_o));

  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(success_o && fail_o));

  p_fail_code_r6: assert property (@(posedge clk) disable iff (rst)
    fail_o |-> (err_code_o != 2'b00));

  p_ok_code_r7: assert property (@(posedge clk) disable iff (rst)
    success_o |-> (err_code_o == 2'b00));

endmodule

bind ps_cfg_master ps_cfg_checker i_ps_cfg_checker (
  .clk         (clk),
  .rst         (rst),
  .cfg_req_n_o (cfg_req_n_o),
  .sclk_o      (sclk_o),
  .sdata_o     (sdata_o),
  .byte_ready_o(byte_ready_o),
  .busy_o      (busy_o),
  .success_o   (success_o),
  .fail_o      (fail_o),
  .err_code_o  (err_code_o)
);

// File: tb/test_ps_cfg_master.sv
`timescale 1ns/1ps
module test_ps_cfg_master;

  localparam int CNT_W = 16;
  localparam int HOLD  = 8;
  localparam int SETL  = 6;
  localparam int TMO   = 300;
  localparam int HALF  = 2;
  localparam int TRAIL = 12;
  localparam int REL_DLY = 20;

  localparam int M_NORMAL = 0;
  localparam int M_STUCK  = 1;
  localparam int M_NEVER  = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] byte_count_i = '0;
  logic [7:0]       byte_data_i = '0;
  logic             byte_valid_i = 1'b0;
  logic             byte_ready_o;
  logic             cfg_req_n_o, sclk_o, sdata_o;
  logic             status_n_i = 1'b1;
  logic             done_i = 1'b0;
  logic             busy_o, success_o, fail_o;
  logic [1:0]       err_code_o;

  int checks = 0;
  int fails  = 0;
  int dev_mode = M_NORMAL;
  int rel_cnt = 0;
  int trail_cnt = 0;
  int cfg_falls = 0;
  int low_len = 0;
  int last_low = 0;
  logic sclk_prev = 1'b0;
  logic cfg_prev = 1'b1;
  logic exp_bits[$];
  logic [7:0] bytes[$];

  always #2 clk = ~clk;

  ps_cfg_master #(
    .CNT_W(CNT_W), .HOLD_CYC(HOLD), .SETTLE_CYC(SETL),
    .TIMEOUT_CYC(TMO), .HALF_CYC(HALF), .TRAIL_CLKS(TRAIL)
  ) i_ps_cfg_master (
    .clk(clk), .rst(rst), .start_i(start_i), .byte_count_i(byte_count_i),
    .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i),
    .byte_ready_o(byte_ready_o), .cfg_req_n_o(cfg_req_n_o),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .status_n_i(status_n_i),
    .done_i(done_i), .busy_o(busy_o), .success_o(success_o),
    .fail_o(fail_o), .err_code_o(err_code_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // target device model: status follows the request line
  initial begin
    forever begin
      @(negedge clk);
      if (dev_mode == M_STUCK) begin
        status_n_i = 1'b1;
      end else if (!cfg_req_n_o) begin
        status_n_i = 1'b0;
        rel_cnt = 0;
      end else if (!status_n_i && dev_mode == M_NORMAL) begin
        rel_cnt++;
        if (rel_cnt >= REL_DLY) status_n_i = 1'b1;
      end
    end
  end

  // monitor: scoreboard pops expected bits on each rising serial clock
  initial begin
    forever begin
      @(negedge clk);
      if (sclk_o && !sclk_prev) begin
        if (exp_bits.size() > 0) begin
          logic b;
          b = exp_bits.pop_front();
          chk(sdata_o == b, "R4 bit order", int'(sdata_o), int'(b));
        end else begin
          trail_cnt++;
        end
      end
      if (!cfg_req_n_o && cfg_prev) cfg_falls++;
      if (!cfg_req_n_o) low_len++;
      else if (low_len > 0) begin
        last_low = low_len;
        low_len = 0;
      end
      sclk_prev = sclk_o;
      cfg_prev  = cfg_req_n_o;
    end
  end

  // driver: pushes expected bits, feeds bytes, runs one load
  task automatic run(input int mode, input bit dn, input bit dbl, output int elapsed);
    int idx;
    int cyc;
    dev_mode = mode;
    done_i = dn;
    trail_cnt = 0;
    cfg_falls = 0;
    last_low = 0;
    exp_bits.delete();
    foreach (bytes[k]) for (int j = 0; j < 8; j++) exp_bits.push_back(bytes[k][j]);
    @(negedge clk);
    start_i = 1'b1;
    byte_count_i = CNT_W'(bytes.size());
    @(negedge clk);
    start_i = 1'b0;
    idx = 0;
    cyc = 0;
    while (busy_o) begin
      start_i = (dbl && cyc == 15);
      if (byte_ready_o && idx < bytes.size() && !byte_valid_i) begin
        byte_valid_i = 1'b1;
        byte_data_i = bytes[idx];
        idx++;
      end else begin
        byte_valid_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    byte_valid_i = 1'b0;
    elapsed = cyc;
  endtask

  task automatic finish_checks(input int exp_err, input string req);
    chk(err_code_o == 2'(exp_err), req, int'(err_code_o), exp_err);
    chk(success_o == (exp_err == 0), req, int'(success_o), int'(exp_err == 0));
    chk(fail_o == (exp_err != 0), req, int'(fail_o), int'(exp_err != 0));
    chk(cfg_req_n_o && !sclk_o && !sdata_o, "R8 parked link",
        int'({cfg_req_n_o, sclk_o, sdata_o}), 4);
  endtask

  initial begin
    int el;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cfg_req_n_o && !sclk_o && !sdata_o && !byte_ready_o, "R1 idle link",
        int'({cfg_req_n_o, sclk_o, sdata_o, byte_ready_o}), 8);
    chk(!busy_o && !success_o && !fail_o && err_code_o == 2'b00, "R1 status",
        int'({busy_o, success_o, fail_o, err_code_o}), 0);

    // R4 R5 R7: normal three-byte load
    bytes = '{8'hA5, 8'h3C, 8'h01};
    run(M_NORMAL, 1'b1, 1'b0, el);
    finish_checks(0, "R7 success");
    chk(exp_bits.size() == 0, "R4 all bits sent", exp_bits.size(), 0);
    chk(trail_cnt == TRAIL, "R7 trailing clocks", trail_cnt, TRAIL);
    chk(last_low >= HOLD, "R2 hold length", last_low, HOLD);
    chk(cfg_falls == 1, "R2 single request", cfg_falls, 1);

    // R10: zero bytes
    bytes.delete();
    run(M_NORMAL, 1'b1, 1'b0, el);
    finish_checks(0, "R10 zero count");
    chk(trail_cnt == TRAIL, "R10 only trailing clocks", trail_cnt, TRAIL);

    // R2: status never asserted
    bytes = '{8'h55};
    run(M_STUCK, 1'b1, 1'b0, el);
    finish_checks(1, "R2 status not asserted");
    chk(trail_cnt == 0, "R2 no clocks", trail_cnt, 0);
    repeat (10) @(negedge clk);
    chk(err_code_o == 2'b01 && fail_o, "R8 error latched", int'(err_code_o), 1);

    // R3: status never released
    run(M_NEVER, 1'b1, 1'b0, el);
    finish_checks(2, "R3 release timeout");
    chk(el >= HOLD + SETL + TMO, "R3 timeout length", el, HOLD + SETL + TMO);
    chk(trail_cnt == 0, "R3 no clocks", trail_cnt, 0);

    // R6: done missing after last byte
    bytes = '{8'h80};
    run(M_NORMAL, 1'b0, 1'b0, el);
    finish_checks(3, "R6 done missing");
    chk(exp_bits.size() == 0, "R6 byte was sent", exp_bits.size(), 0);
    chk(trail_cnt == 0, "R6 no trailing clocks", trail_cnt, 0);

    // R9: second start during a load; error from before is cleared
    bytes = '{8'hFF, 8'h00};
    run(M_NORMAL, 1'b1, 1'b1, el);
    finish_checks(0, "R9 load unaffected");
    chk(cfg_falls == 1, "R9 start ignored", cfg_falls, 1);
    chk(exp_bits.size() == 0, "R9 all bits sent", exp_bits.size(), 0);
    chk(trail_cnt == TRAIL, "R9 trailing clocks", trail_cnt, TRAIL);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule